// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Miss Classification

This block is a small read-only cache with one line per set, placed between a byte-wide requester and a backing memory that delivers whole blocks. Each byte address is split into three fields. The low bits give the byte offset within the block, the middle bits pick the set, and the high bits form the tag that is compared against the stored line. A read whose selected line is valid and holds a matching tag returns the byte from the cache. Any other read fetches the whole block from memory, installs it in the line, and then returns the byte.

Each response also reports how the access was resolved: as a hit, or as one of three kinds of miss. A cold miss is the first reference to a block since reset. A conflict miss is a block that a fully associative cache of the same total size would still hold. A capacity miss is a block that even such a cache would have evicted. Four saturating counters, one per outcome, let a designer measure how well an access pattern suits the cache geometry.

Top module: `dm_cache_classify`

## Requirements
- R1: The address is split as offset = addr[OFF_W-1:0], set = addr[OFF_W+IDX_W-1:OFF_W] and tag = the remaining high bits. Blocks with consecutive numbers therefore land in different sets, so with the default geometry the reads 0, 2, 4 and 6 can all be resident at once.
- R2: A hit happens only when the selected line is valid and its tag matches. On a hit, rsp_valid_o pulses for one cycle, in the cycle after the request is accepted. rsp_hit_o is 1, rsp_class_o is 0, rsp_data_o holds the byte at the offset, and no fill is requested.
- R3: On a miss, fill_req_o rises with fill_addr_o = addr >> OFF_W and holds both steady until fill_valid_i. req_ready_o stays low for the whole fill. Byte k of the block is fill_data_i[8k+7:8k]. The line is written and marked valid, and the response follows one cycle after the fill handshake.
- R4: From reset, reading 0, 1, 13, 8 and 0 gives miss, hit, miss, miss, miss.
- R5: A miss on a block not referenced since reset reports rsp_class_o = 1 (cold).
- R6: A miss on an already referenced block that is among the SETS most recently used distinct blocks reports rsp_class_o = 2 (conflict).
- R7: A miss on an already referenced block that is not among those blocks reports rsp_class_o = 3 (capacity).
- R8: From reset, alternating reads of 0 and 8 miss every time: the first two are cold, and every one after that is a conflict miss.
- R9: Reset clears the counters hit_cnt_o, cold_cnt_o, conf_cnt_o and cap_cnt_o. Each counter increases by one in the cycle its class is reported, and stops at 2^CNT_W-1.
- R10: After reset, req_ready_o = 1, rsp_valid_o = 0, fill_req_o = 0, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_addr_i | input | ADDR_W | Byte address |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_hit_o | output | 1 | Response was a hit |
| rsp_class_o | output | 2 | 0 hit, 1 cold, 2 conflict, 3 capacity |
| rsp_data_o | output | 8 | Returned byte |
| fill_req_o | output | 1 | Block fetch request |
| fill_addr_o | output | ADDR_W-OFF_W | Block number to fetch |
| fill_valid_i | input | 1 | Block data valid, completes the fetch |
| fill_data_i | input | 8*2^OFF_W | Whole block, byte 0 in the low bits |
| hit_cnt_o | output | CNT_W | Hit count |
| cold_cnt_o | output | CNT_W | Cold miss count |
| conf_cnt_o | output | CNT_W | Conflict miss count |
| cap_cnt_o | output | CNT_W | Capacity miss count |

## Verification
A hit response is due on the first falling edge after the accepting rising edge. A miss response is due one edge after the edge that takes fill_valid_i. The counters change at the same edge as the response, so they are read in that same response cycle. The bench drives requests and fill data only on falling edges. It then steps one falling edge at a time until rsp_valid_o is high, and checks there that a hit arrived with no wait. During that stepping it also samples fill_addr_o and req_ready_o while the fill is outstanding.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    CL_HIT  = 2'd0,
    CL_COLD = 2'd1,
    CL_CONF = 2'd2,
    CL_CAP  = 2'd3
  } acc_cls_e;
endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 1,
  parameter int LINE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  output logic              rd_hit_o,
  output logic [LINE_W-1:0] rd_line_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [LINE_W-1:0] wr_line_i
);
  localparam int SETS = 2 ** IDX_W;

  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  assign rd_hit_o  = vld_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign rd_line_o = line_q[rd_idx_i];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s]  <= 1'b0;
        tag_q[s]  <= '0;
        line_q[s] <= '0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(s)) begin
        vld_q[s]  <= 1'b1;
        tag_q[s]  <= wr_tag_i;
        line_q[s] <= wr_line_i;
      end
    end
  end
endmodule

// File: rtl/dmc_shadow_lru.sv
// Fully associative LRU tag store, same line count as the real cache.
module dmc_shadow_lru #(
  parameter int WAYS  = 4,
  parameter int BLK_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             hit_o
);
  localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]  vld_q;
  logic [BLK_W-1:0] blk_q [WAYS];
  logic [AGE_W-1:0] age_q [WAYS];

  logic [WAYS-1:0]  hit_vec;
  logic [AGE_W-1:0] hit_age, sel_age;
  logic [AGE_W-1:0] hit_way, vic_way, sel_way;

  always_comb begin
    hit_age = '0;
    hit_way = '0;
    vic_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      hit_vec[i] = vld_q[i] && (blk_q[i] == blk_i);
      if (hit_vec[i]) begin
        hit_way = AGE_W'(i);
        hit_age = age_q[i];
      end
      if (age_q[i] == AGE_W'(WAYS - 1)) vic_way = AGE_W'(i);
    end
  end

  assign hit_o   = |hit_vec;
  assign sel_way = hit_o ? hit_way : vic_way;
  assign sel_age = hit_o ? hit_age : AGE_W'(WAYS - 1);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[w] <= 1'b0;
        blk_q[w] <= '0;
        age_q[w] <= AGE_W'(WAYS - 1 - w);
      end else if (acc_i) begin
        if (sel_way == AGE_W'(w)) begin
          vld_q[w] <= 1'b1;
          blk_q[w] <= blk_i;
          age_q[w] <= '0;
        end else if (age_q[w] < sel_age) begin
          age_q[w] <= age_q[w] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dmc_sat_cnt.sv
module dmc_sat_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (inc_i && ~&cnt_o)     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dm_cache_classify.sv
module dm_cache_classify
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int OFF_W  = 1,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 8,
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int LINE_W = 8 * (2 ** OFF_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [1:0]        rsp_class_o,
  output logic [7:0]        rsp_data_o,
  output logic              fill_req_o,
  output logic [BLK_W-1:0]  fill_addr_o,
  input  logic              fill_valid_i,
  input  logic [LINE_W-1:0] fill_data_i,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  cold_cnt_o,
  output logic [CNT_W-1:0]  conf_cnt_o,
  output logic [CNT_W-1:0]  cap_cnt_o
);
  localparam int SETS = 2 ** IDX_W;
  localparam int NBLK = 2 ** BLK_W;

  typedef enum logic {ST_IDLE, ST_FILL} st_e;
  st_e st_q;

  logic [OFF_W-1:0]  req_off;
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic [BLK_W-1:0]  req_blk;
  logic              accept;

  logic              ln_hit;
  logic [LINE_W-1:0] ln_data;
  logic              sh_hit;
  logic [NBLK-1:0]   seen_q;
  acc_cls_e          acc_cls;

  logic [ADDR_W-1:0] pend_addr_q;
  acc_cls_e          pend_cls_q;
  logic              fill_done;

  logic              rsp_load;
  acc_cls_e          rsp_cls_d;
  logic [7:0]        rsp_data_d;
  acc_cls_e          rsp_cls_q;

  assign req_off = req_addr_i[OFF_W-1:0];
  assign req_idx = req_addr_i[OFF_W +: IDX_W];
  assign req_tag = req_addr_i[ADDR_W-1 -: TAG_W];
  assign req_blk = req_addr_i[ADDR_W-1:OFF_W];

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign fill_req_o  = (st_q == ST_FILL);
  assign fill_addr_o = pend_addr_q[ADDR_W-1:OFF_W];
  assign fill_done   = fill_req_o && fill_valid_i;

  dmc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_lines (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (req_idx),
    .rd_tag_i  (req_tag),
    .rd_hit_o  (ln_hit),
    .rd_line_o (ln_data),
    .wr_en_i   (fill_done),
    .wr_idx_i  (pend_addr_q[OFF_W +: IDX_W]),
    .wr_tag_i  (pend_addr_q[ADDR_W-1 -: TAG_W]),
    .wr_line_i (fill_data_i)
  );

  dmc_shadow_lru #(.WAYS(SETS), .BLK_W(BLK_W)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (accept),
    .blk_i  (req_blk),
    .hit_o  (sh_hit)
  );

  // classification uses state before this access updates it
  always_comb begin
    if (ln_hit)                acc_cls = CL_HIT;
    else if (!seen_q[req_blk]) acc_cls = CL_COLD;
    else if (sh_hit)           acc_cls = CL_CONF;
    else                       acc_cls = CL_CAP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (accept) seen_q[req_blk] <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      pend_addr_q <= '0;
      pend_cls_q  <= CL_HIT;
    end else begin
      case (st_q)
        ST_IDLE: if (accept && !ln_hit) begin
          st_q        <= ST_FILL;
          pend_addr_q <= req_addr_i;
          pend_cls_q  <= acc_cls;
        end
        ST_FILL: if (fill_valid_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rsp_load   = 1'b0;
    rsp_cls_d  = CL_HIT;
    rsp_data_d = '0;
    if (accept && ln_hit) begin
      rsp_load   = 1'b1;
      rsp_data_d = ln_data[{req_off, 3'b000} +: 8];
    end else if (fill_done) begin
      rsp_load   = 1'b1;
      rsp_cls_d  = pend_cls_q;
      rsp_data_d = fill_data_i[{pend_addr_q[OFF_W-1:0], 3'b000} +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_cls_q   <= CL_HIT;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= rsp_load;
      if (rsp_load) begin
        rsp_cls_q  <= rsp_cls_d;
        rsp_data_o <= rsp_data_d;
      end
    end
  end

  assign rsp_class_o = rsp_cls_q;
  assign rsp_hit_o   = (rsp_cls_q == CL_HIT);

  logic [CNT_W-1:0] cnt_w [4];

  for (genvar g = 0; g < 4; g++) begin : g_cnt
    dmc_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (rsp_load && (rsp_cls_d == acc_cls_e'(g))),
      .cnt_o  (cnt_w[g])
    );
  end

  assign hit_cnt_o  = cnt_w[0];
  assign cold_cnt_o = cnt_w[1];
  assign conf_cnt_o = cnt_w[2];
  assign cap_cnt_o  = cnt_w[3];
endmodule

// File: rtl/dm_cache_classify_chk.sv
module dm_cache_classify_chk #(
  parameter int BLK_W = 3,
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic [1:0]       rsp_class_o,
  input logic             fill_req_o,
  input logic [BLK_W-1:0] fill_addr_o,
  input logic             fill_valid_i,
  input logic [CNT_W-1:0] hit_cnt_o
);
  p_ready_low_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o |-> !req_ready_o);

  p_fill_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o && !fill_valid_i |=> fill_req_o && $stable(fill_addr_o));

  p_rsp_after_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o && fill_valid_i |=> rsp_valid_o && rsp_class_o != 2'd0);

  p_hit_next_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_class_o == 2'd0 |-> $past(req_valid_i && req_ready_o));

  p_accept_progress_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> fill_req_o || rsp_valid_o);

  p_hit_cnt_mono_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> hit_cnt_o >= $past(hit_cnt_o));
endmodule

bind dm_cache_classify dm_cache_classify_chk #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_class_o (rsp_class_o),
  .fill_req_o  (fill_req_o),
  .fill_addr_o (fill_addr_o),
  .fill_valid_i(fill_valid_i),
  .hit_cnt_o   (hit_cnt_o)
);

// File: tb/dm_cache_classify_bench.sv
`timescale 1ns/1ps
module dm_cache_classify_bench;
  localparam int HIT = 0, COLD = 1, CONF = 2, CAP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_addr = '0;
  logic        req_ready;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_class;
  logic [7:0]  rsp_data;
  logic        fill_req;
  logic [2:0]  fill_addr;
  logic        fill_valid = 1'b0;
  logic [15:0] fill_data = '0;
  logic [7:0]  hit_cnt, cold_cnt, conf_cnt, cap_cnt;

  int total = 0;
  int bad = 0;
  int dly = 0;

  always #2 clk = ~clk;

  dm_cache_classify u_dm_cache_classify (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_class_o(rsp_class),
    .rsp_data_o(rsp_data),
    .fill_req_o(fill_req), .fill_addr_o(fill_addr),
    .fill_valid_i(fill_valid), .fill_data_i(fill_data),
    .hit_cnt_o(hit_cnt), .cold_cnt_o(cold_cnt),
    .conf_cnt_o(conf_cnt), .cap_cnt_o(cap_cnt)
  );

  function automatic logic [7:0] mem_byte(input logic [3:0] a);
    return 8'(a * 29 + 7);
  endfunction

  // backing memory: answers a fill after a short delay
  always @(negedge clk) begin
    if (fill_valid) begin
      fill_valid <= 1'b0;
    end else if (fill_req) begin
      if (dly == 2) begin
        fill_valid <= 1'b1;
        fill_data  <= {mem_byte({fill_addr, 1'b1}), mem_byte({fill_addr, 1'b0})};
        dly        <= 0;
      end else begin
        dly <= dly + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input int ecls, input string rq);
    bit saw_fill = 0;
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && n < 50) begin
      if (fill_req && !saw_fill) begin
        saw_fill = 1;
        chk(fill_addr == a[3:1], "R3 fill address", int'(fill_addr), int'(a[3:1]));
        chk(req_ready == 1'b0, "R3 ready low during fill", int'(req_ready), 0);
      end
      @(negedge clk);
      n++;
    end
    chk(rsp_valid == 1'b1, rq, int'(rsp_valid), 1);
    chk(int'(rsp_class) == ecls, rq, int'(rsp_class), ecls);
    chk(rsp_data == mem_byte(a), {rq, " data"}, int'(rsp_data), int'(mem_byte(a)));
    chk(rsp_hit == (ecls == HIT), {rq, " hit flag"}, int'(rsp_hit), int'(ecls == HIT));
    if (ecls == HIT) chk(n == 0 && !saw_fill, "R2 hit in one cycle, no fill", n, 0);
    else             chk(saw_fill, "R3 miss requests a fill", int'(saw_fill), 1);
  endtask

  task automatic t_reset();
    do_reset();
    chk(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R10 no response after reset", int'(rsp_valid), 0);
    chk(fill_req == 1'b0, "R10 no fill after reset", int'(fill_req), 0);
    chk(hit_cnt == 0 && cold_cnt == 0 && conf_cnt == 0 && cap_cnt == 0,
        "R9 counters clear", int'(hit_cnt) + int'(cold_cnt) + int'(conf_cnt) + int'(cap_cnt), 0);
  endtask

  task automatic t_trace();
    do_reset();
    rd(4'd0,  COLD, "R4 R5 read 0 cold");
    rd(4'd1,  HIT,  "R4 R2 read 1 hit");
    rd(4'd13, COLD, "R4 read 13 cold");
    rd(4'd8,  COLD, "R4 read 8 cold");
    rd(4'd0,  CONF, "R4 R6 read 0 conflict");
    chk(hit_cnt == 1,  "R9 hit count", int'(hit_cnt), 1);
    chk(cold_cnt == 3, "R9 cold count", int'(cold_cnt), 3);
    chk(conf_cnt == 1, "R9 conflict count", int'(conf_cnt), 1);
    chk(cap_cnt == 0,  "R9 capacity count", int'(cap_cnt), 0);
  endtask

  task automatic t_pingpong();
    do_reset();
    rd(4'd0, COLD, "R8 first 0");
    rd(4'd8, COLD, "R8 first 8");
    for (int i = 0; i < 3; i++) begin
      rd(4'd0, CONF, "R8 R6 repeat 0");
      rd(4'd8, CONF, "R8 R6 repeat 8");
    end
    chk(conf_cnt == 6 && hit_cnt == 0, "R8 conflict count", int'(conf_cnt), 6);
  endtask

  task automatic t_spread();
    do_reset();
    for (int i = 0; i < 4; i++) rd(4'(2 * i), COLD, "R1 fill all sets");
    for (int i = 0; i < 4; i++) rd(4'(2 * i + 1), HIT, "R1 neighbours resident");
    rd(4'd8, COLD, "R5 block 4 cold");
    rd(4'd0, CAP,  "R7 block 0 capacity");
    rd(4'd3, HIT,  "R2 set 1 untouched");
    rd(4'd9, CONF, "R6 block 4 conflict");
    chk(cap_cnt == 1, "R9 capacity count", int'(cap_cnt), 1);
  endtask

  task automatic t_saturate();
    do_reset();
    rd(4'd5, COLD, "R9 warm up");
    for (int i = 0; i < 300; i++) rd(4'd4, HIT, "R9 repeated hit");
    chk(hit_cnt == 8'd255, "R9 hit counter saturates", int'(hit_cnt), 255);
    chk(cold_cnt == 8'd1, "R9 other counter untouched", int'(cold_cnt), 1);
  endtask

  initial begin
    t_reset();
    t_trace();
    t_pingpong();
    t_spread();
    t_saturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule